// File: doc/BRIEF.md
# Interrupt Entry Bus Sequencer

This block sits inside a processor core and takes over the external bus for the few machine cycles between the end of an interrupted instruction and the first fetch of its service routine. When the core signals that the last T-state of an instruction is under way and an interrupt is pending, the sequencer latches the program counter and stack pointer and then runs one of two entry paths. One clock is one T-state.

A direct source gets a silent six-T-state idle cycle. The sequencer then pushes the program counter and loads a preset vector for that source. The vectored source gets an acknowledge cycle shaped like an opcode fetch, and the interrupting device jams an opcode during it. A three-byte call opcode brings two further acknowledge cycles that collect the target address, low byte first. A restart opcode selects one of eight fixed targets spaced eight bytes apart. Both paths end with two stack writes and a single-cycle load of the new PC and SP. Priority between sources is resolved upstream and arrives here as a source index.

Top module: `irq_entry_seq`

## Requirements
- R1: While reset is applied, and afterwards until an entry starts, `busy`, `wr_stb`, `ack_stb`, `accept`, `ir_load`, `pc_load` and `sp_load` are all 0.
- R2: An entry starts only at a clock edge where `instr_end` and `irq_pending` are both 1 while the block is not busy. `irq_pending` without `instr_end`, or `instr_end` without `irq_pending`, starts nothing.
- R3: `accept` is high for exactly one T-state per entry: the first T-state after the starting edge.
- R4: For a direct entry (`irq_vectored`=0), the first six T-states form an idle cycle. During it `wr_stb` and `ack_stb` stay 0 and `ready` has no effect on its length.
- R5: The push is two write cycles of three T-states each. The first writes PC[15:8] to SP-1 and the second writes PC[7:0] to SP-2, using the PC and SP latched at the starting edge. `wr_stb` is high in the second and third T-states of each write cycle. `ready`=0 in the third T-state repeats that T-state.
- R6: In the last T-state of the second write, `pc_load` and `sp_load` pulse for one cycle with `sp_new` = SP-2. For a direct entry `pc_new` is the parameter vector `DIRECT_VEC[irq_src]`. `busy` falls on the next cycle.
- R7: A vectored entry starts with a six-T-state acknowledge cycle. `ack_stb` is high in T-states 2 and 3, `addr` holds the latched PC and is not incremented, and `ready`=0 in T-state 3 repeats it. The byte on `data_in` at the end of T-state 3 is shown on `ir_byte`, with `ir_load` pulsing in the following T-state.
- R8: If that byte equals `CALL_OP` (default 0xCD), two three-T-state acknowledge cycles follow. They capture the low address byte and then the high byte, and `pc_new` is {high, low}.
- R9: If the byte has the form 11nnn111 and is not `CALL_OP`, `pc_new` is 8*n.
- R10: Any other jammed byte ends the entry after the acknowledge cycle, with no write cycle and no `pc_load`.
- R11: `wr_stb` and `ack_stb` are never high together, and `instr_end` or `irq_pending` during an entry start no second entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | T-state clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_end | input | 1 | Last T-state of the current instruction |
| irq_pending | input | 1 | An enabled interrupt is pending |
| irq_vectored | input | 1 | 1: the pending source is the vectored one |
| irq_src | input | SRC_W | Index of the pending direct source |
| pc_in | input | 16 | Current program counter |
| sp_in | input | 16 | Current stack pointer |
| ready | input | 1 | Bus ready; 0 inserts wait states |
| data_in | input | 8 | Data bus input (jammed bytes) |
| busy | output | 1 | An entry sequence owns the bus |
| accept | output | 1 | Entry accepted; clears the global enable |
| addr | output | 16 | Bus address during the entry |
| data_out | output | 8 | Write data |
| wr_stb | output | 1 | Write strobe |
| ack_stb | output | 1 | Interrupt acknowledge strobe |
| ir_load | output | 1 | Load `ir_byte` into the instruction register |
| ir_byte | output | 8 | Jammed opcode |
| pc_load | output | 1 | Load `pc_new` into the PC |
| pc_new | output | 16 | New program counter |
| sp_load | output | 1 | Load `sp_new` into the SP |
| sp_new | output | 16 | New stack pointer |

## Verification
The bench builds the block with four direct sources whose vectors are overridden to distinct, non-aligned values. A wrong index or a byte swap in the vector select then shows up directly on `pc_new`. Idle, acknowledge and write lengths stay at their defaults of six, six and three T-states. Every cycle boundary therefore falls at a fixed, countable index, and `ready` wait states can be placed exactly in the idle cycle, in the sampling T-state of the acknowledge cycle, and in the sampling T-state of the first write. The jammed bytes cover the call code, the restart indices 0, 5 and 7, and a byte of neither form.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

    typedef enum logic [2:0] {
        ST_RUN     = 3'd0,
        ST_IDLE    = 3'd1,
        ST_ACK_OP  = 3'd2,
        ST_ACK_LO  = 3'd3,
        ST_ACK_HI  = 3'd4,
        ST_PUSH_HI = 3'd5,
        ST_PUSH_LO = 3'd6
    } entry_state_e;

    // T-state index (counted from 0) in which a bus cycle samples ready/data
    localparam int unsigned SAMPLE_T = 2;

endpackage

// File: rtl/irq_op_decode.sv
module irq_op_decode #(
    parameter logic [7:0] CALL_OP = 8'hCD
) (
    input  logic [7:0]  op,
    output logic        is_call,
    output logic        is_restart,
    output logic [15:0] restart_tgt
);
    always_comb begin
        is_call     = (op == CALL_OP);
        is_restart  = !is_call && (op[7:6] == 2'b11) && (op[2:0] == 3'b111);
        restart_tgt = {10'd0, op[5:3], 3'b000};
    end
endmodule

// File: rtl/irq_vec_sel.sv
module irq_vec_sel #(
    parameter int unsigned NUM_DIRECT = 4,
    parameter int unsigned SRC_W      = $clog2(NUM_DIRECT),
    parameter logic [NUM_DIRECT-1:0][15:0] DIRECT_VEC = '0
) (
    input  logic [SRC_W-1:0] src,
    output logic [15:0]      vec
);
    logic [NUM_DIRECT-1:0][15:0] term;

    for (genvar i = 0; i < NUM_DIRECT; i++) begin : g_term
        assign term[i] = (src == SRC_W'(i)) ? DIRECT_VEC[i] : 16'd0;
    end

    always_comb begin
        vec = 16'd0;
        for (int i = 0; i < NUM_DIRECT; i++) begin
            vec = vec | term[i];
        end
    end
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
    import irq_entry_pkg::*;
#(
    parameter int unsigned NUM_DIRECT = 4,
    parameter int unsigned SRC_W      = $clog2(NUM_DIRECT),
    parameter logic [NUM_DIRECT-1:0][15:0] DIRECT_VEC =
        {16'h0C00, 16'h0800, 16'h0400, 16'h0200},
    parameter logic [7:0]  CALL_OP    = 8'hCD,
    parameter int unsigned IDLE_T     = 6,
    parameter int unsigned ACK_T      = 6,
    parameter int unsigned MEM_T      = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             instr_end,
    input  logic             irq_pending,
    input  logic             irq_vectored,
    input  logic [SRC_W-1:0] irq_src,
    input  logic [15:0]      pc_in,
    input  logic [15:0]      sp_in,
    input  logic             ready,
    input  logic [7:0]       data_in,
    output logic             busy,
    output logic             accept,
    output logic [15:0]      addr,
    output logic [7:0]       data_out,
    output logic             wr_stb,
    output logic             ack_stb,
    output logic             ir_load,
    output logic [7:0]       ir_byte,
    output logic             pc_load,
    output logic [15:0]      pc_new,
    output logic             sp_load,
    output logic [15:0]      sp_new
);
    localparam int unsigned MAX_T = (IDLE_T > ACK_T)
                                  ? ((IDLE_T > MEM_T) ? IDLE_T : MEM_T)
                                  : ((ACK_T > MEM_T) ? ACK_T : MEM_T);
    localparam int unsigned TW    = $clog2(MAX_T + 1);

    typedef struct packed {
        entry_state_e   state;
        logic [TW-1:0]  tcnt;
        logic [15:0]    pc;
        logic [15:0]    sp;
        logic [15:0]    tgt;
        logic [7:0]     op;
    } seq_regs_t;

    seq_regs_t q, d;

    logic        is_call, is_restart;
    logic [15:0] restart_tgt, direct_vec;
    logic [15:0] pc_base, sp_base;

    irq_op_decode #(.CALL_OP(CALL_OP)) u_dec (
        .op          (q.op),
        .is_call     (is_call),
        .is_restart  (is_restart),
        .restart_tgt (restart_tgt)
    );

    irq_vec_sel #(
        .NUM_DIRECT (NUM_DIRECT),
        .SRC_W      (SRC_W),
        .DIRECT_VEC (DIRECT_VEC)
    ) u_vec (
        .src (irq_src),
        .vec (direct_vec)
    );

    assign pc_base = q.pc;
    assign sp_base = q.sp;

    logic [TW-1:0] last_t;
    logic          uses_ready, hold, fin, in_win, capture;

    always_comb begin
        unique case (q.state)
            ST_IDLE:   last_t = TW'(IDLE_T - 1);
            ST_ACK_OP: last_t = TW'(ACK_T - 1);
            default:   last_t = TW'(MEM_T - 1);
        endcase
        uses_ready = (q.state != ST_RUN) && (q.state != ST_IDLE);
        hold       = uses_ready && (q.tcnt == TW'(SAMPLE_T)) && !ready;
        capture    = uses_ready && (q.tcnt == TW'(SAMPLE_T)) && ready;
        fin        = !hold && (q.tcnt == last_t);
        in_win     = (q.tcnt >= TW'(1)) && (q.tcnt <= TW'(SAMPLE_T));
    end

    always_comb begin
        d        = q;
        addr     = 16'd0;
        data_out = 8'd0;
        wr_stb   = 1'b0;
        ack_stb  = 1'b0;
        ir_load  = 1'b0;
        pc_load  = 1'b0;
        sp_load  = 1'b0;
        pc_new   = q.tgt;
        sp_new   = q.sp - 16'd2;
        busy     = (q.state != ST_RUN);
        accept   = ((q.state == ST_IDLE) || (q.state == ST_ACK_OP))
                   && (q.tcnt == '0);
        ir_byte  = q.op;

        if (q.state != ST_RUN) begin
            d.tcnt = hold ? q.tcnt : (fin ? '0 : q.tcnt + TW'(1));
        end

        unique case (q.state)
            ST_RUN: begin
                if (instr_end && irq_pending) begin
                    d.state = irq_vectored ? ST_ACK_OP : ST_IDLE;
                    d.tcnt  = '0;
                    d.pc    = pc_in;
                    d.sp    = sp_in;
                    d.tgt   = direct_vec;
                    d.op    = 8'd0;
                end
            end
            ST_IDLE: begin
                addr = q.pc;
                if (fin) d.state = ST_PUSH_HI;
            end
            ST_ACK_OP: begin
                addr    = q.pc;
                ack_stb = in_win;
                ir_load = (q.tcnt == TW'(SAMPLE_T + 1));
                if (capture) d.op = data_in;
                if (fin) begin
                    if (is_call) begin
                        d.state = ST_ACK_LO;
                    end else if (is_restart) begin
                        d.state = ST_PUSH_HI;
                        d.tgt   = restart_tgt;
                    end else begin
                        d.state = ST_RUN;
                    end
                end
            end
            ST_ACK_LO: begin
                addr    = q.pc;
                ack_stb = in_win;
                if (capture) d.tgt[7:0] = data_in;
                if (fin) d.state = ST_ACK_HI;
            end
            ST_ACK_HI: begin
                addr    = q.pc;
                ack_stb = in_win;
                if (capture) d.tgt[15:8] = data_in;
                if (fin) d.state = ST_PUSH_HI;
            end
            ST_PUSH_HI: begin
                addr     = q.sp - 16'd1;
                data_out = q.pc[15:8];
                wr_stb   = in_win;
                if (fin) d.state = ST_PUSH_LO;
            end
            ST_PUSH_LO: begin
                addr     = q.sp - 16'd2;
                data_out = q.pc[7:0];
                wr_stb   = in_win;
                if (fin) begin
                    pc_load = 1'b1;
                    sp_load = 1'b1;
                    d.state = ST_RUN;
                end
            end
            default: d.state = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{state: ST_RUN, tcnt: '0, pc: 16'd0, sp: 16'd0,
                   tgt: 16'd0, op: 8'd0};
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/irq_entry_chk.sv
module irq_entry_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        accept,
    input logic        wr_stb,
    input logic        ack_stb,
    input logic [15:0] addr,
    input logic        pc_load,
    input logic        sp_load,
    input logic [15:0] sp_new,
    input logic [15:0] pc_base,
    input logic [15:0] sp_base
);
    // R1
    a_r1_quiet_when_free: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(wr_stb || ack_stb || accept));

    // R3
    a_r3_accept_single: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !accept);

    // R3
    a_r3_accept_at_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> accept);

    // R5
    a_r5_push_addr: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> (addr == sp_base - 16'd1 || addr == sp_base - 16'd2));

    // R6
    a_r6_load_pair: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |-> (sp_load && sp_new == sp_base - 16'd2));

    // R6
    a_r6_load_ends: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |=> !busy);

    // R7
    a_r7_ack_addr: assert property (@(posedge clk) disable iff (!rst_n)
        ack_stb |-> addr == pc_base);

    // R11
    a_r11_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_stb, ack_stb}));
endmodule

bind irq_entry_seq irq_entry_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (busy),
    .accept  (accept),
    .wr_stb  (wr_stb),
    .ack_stb (ack_stb),
    .addr    (addr),
    .pc_load (pc_load),
    .sp_load (sp_load),
    .sp_new  (sp_new),
    .pc_base (pc_base),
    .sp_base (sp_base)
);

// File: tb/tb_irq_entry_seq.sv
module tb_irq_entry_seq;
    localparam logic [3:0][15:0] VECS = {16'h3C3C, 16'h2A50, 16'h1234, 16'h0F0E};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_end = 1'b0, irq_pending = 1'b0, irq_vectored = 1'b0;
    logic [1:0]  irq_src = 2'd0;
    logic [15:0] pc_in = 16'd0, sp_in = 16'd0;
    logic        ready = 1'b1;
    logic [7:0]  data_in = 8'd0;
    logic        busy, accept, wr_stb, ack_stb, ir_load, pc_load, sp_load;
    logic [15:0] addr, pc_new, sp_new;
    logic [7:0]  data_out, ir_byte;

    always #5 clk = ~clk;

    irq_entry_seq #(.NUM_DIRECT(4), .DIRECT_VEC(VECS)) dut (
        .clk(clk), .rst_n(rst_n), .instr_end(instr_end), .irq_pending(irq_pending),
        .irq_vectored(irq_vectored), .irq_src(irq_src), .pc_in(pc_in), .sp_in(sp_in),
        .ready(ready), .data_in(data_in), .busy(busy), .accept(accept), .addr(addr),
        .data_out(data_out), .wr_stb(wr_stb), .ack_stb(ack_stb), .ir_load(ir_load),
        .ir_byte(ir_byte), .pc_load(pc_load), .pc_new(pc_new), .sp_load(sp_load),
        .sp_new(sp_new));

    int n_chk = 0, n_err = 0;

    // per-T-state log of one entry, index 0 = first T-state
    logic        lg_wr[64], lg_ack[64], lg_acc[64], lg_irl[64], lg_load[64], lg_busy[64];
    logic [15:0] lg_addr[64], lg_pcn[64], lg_spn[64];
    logic [7:0]  lg_dout[64], lg_irb[64];
    int          end_k;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int count_set(input int which);
        int c = 0;
        for (int k = 0; k < 64; k++) begin
            case (which)
                0: c += int'(lg_wr[k]);
                1: c += int'(lg_ack[k]);
                2: c += int'(lg_acc[k]);
                default: c += int'(lg_load[k]);
            endcase
        end
        return c;
    endfunction

    task automatic run_entry(input bit vect, input logic [1:0] src,
                             input logic [15:0] pc, input logic [15:0] sp,
                             input logic [63:0] stall, input logic [7:0] j0,
                             input logic [7:0] j1, input logic [7:0] j2,
                             input bit poke);
        int acks = 0;
        bit prev_ack = 1'b0;
        logic [7:0] jam[3];
        jam[0] = j0; jam[1] = j1; jam[2] = j2;
        end_k = -1;
        @(negedge clk);
        instr_end = 1'b1; irq_pending = 1'b1; irq_vectored = vect;
        irq_src = src; pc_in = pc; sp_in = sp;
        @(negedge clk);
        pc_in = 16'hFFFF; sp_in = 16'h5555;
        for (int k = 0; k < 64; k++) begin
            lg_wr[k] = wr_stb; lg_ack[k] = ack_stb; lg_acc[k] = accept;
            lg_irl[k] = ir_load; lg_load[k] = pc_load; lg_busy[k] = busy;
            lg_addr[k] = addr; lg_pcn[k] = pc_new; lg_spn[k] = sp_new;
            lg_dout[k] = data_out; lg_irb[k] = ir_byte;
            if (!busy && end_k < 0) end_k = k;
            if (ack_stb && !prev_ack) begin
                data_in = (acks < 3) ? jam[acks] : 8'h00;
                acks++;
            end
            prev_ack = ack_stb;
            ready = ~stall[k];
            instr_end = poke && (k < 8) && busy && k[0];
            irq_pending = poke && (k < 8) && busy;
            @(negedge clk);
        end
        instr_end = 1'b0; irq_pending = 1'b0; ready = 1'b1;
    endtask

    task automatic t_reset;
        chk(!busy && !wr_stb && !ack_stb && !accept, "R1 reset strobes", {busy, wr_stb, ack_stb, accept}, 0);
        chk(!pc_load && !sp_load && !ir_load, "R1 reset loads", {pc_load, sp_load, ir_load}, 0);
    endtask

    task automatic t_no_entry;
        @(negedge clk);
        irq_pending = 1'b1; instr_end = 1'b0;
        repeat (4) @(negedge clk);
        chk(!busy && !accept, "R2 pending alone", busy, 0);
        irq_pending = 1'b0; instr_end = 1'b1;
        repeat (4) @(negedge clk);
        chk(!busy && !accept, "R2 instr_end alone", busy, 0);
        instr_end = 1'b0;
    endtask

    task automatic t_direct_plain;
        run_entry(1'b0, 2'd2, 16'hA1B2, 16'h8000, 64'd0, 8'h0, 8'h0, 8'h0, 1'b0);
        chk(lg_acc[0] && count_set(2) == 1, "R3 accept once at start", count_set(2), 1);
        chk(count_set(1) == 0, "R4 no ack in direct", count_set(1), 0);
        for (int k = 0; k < 6; k++) chk(!lg_wr[k], "R4 idle silent", lg_wr[k], 0);
        chk(lg_wr[7] && lg_wr[8] && !lg_wr[6] && count_set(0) == 4, "R5 write strobes", count_set(0), 4);
        chk(lg_addr[7] == 16'h7FFF && lg_dout[7] == 8'hA1, "R5 high byte push", {lg_addr[7], lg_dout[7]}, 24'h7FFFA1);
        chk(lg_addr[10] == 16'h7FFE && lg_dout[10] == 8'hB2, "R5 low byte push", {lg_addr[10], lg_dout[10]}, 24'h7FFEB2);
        chk(lg_load[11] && count_set(3) == 1, "R6 load timing", count_set(3), 1);
        chk(lg_pcn[11] == 16'h2A50, "R6 direct vector", lg_pcn[11], 16'h2A50);
        chk(lg_spn[11] == 16'h7FFE, "R6 sp_new", lg_spn[11], 16'h7FFE);
        chk(end_k == 12, "R6 busy falls", end_k, 12);
    endtask

    task automatic t_direct_waits;
        // ready low throughout idle, and in T3 of the first write
        run_entry(1'b0, 2'd0, 16'h0102, 16'h0001, 64'h13F, 8'h0, 8'h0, 8'h0, 1'b1);
        chk(lg_wr[7] && lg_wr[8] && lg_wr[9] && !lg_wr[6], "R4 idle ignores ready", {lg_wr[6], lg_wr[7]}, 1);
        chk(lg_addr[11] == 16'hFFFF && lg_wr[11], "R5 wait stretches write", lg_addr[11], 16'hFFFF);
        chk(lg_load[12] && lg_pcn[12] == 16'h0F0E, "R6 vector src0", lg_pcn[12], 16'h0F0E);
        chk(lg_spn[12] == 16'hFFFF, "R6 sp wraps", lg_spn[12], 16'hFFFF);
        chk(count_set(2) == 1 && count_set(3) == 1 && end_k == 13, "R11 no re-entry while busy", end_k, 13);
    endtask

    task automatic t_restart(input logic [7:0] op, input logic [15:0] exp_pc, input bit stall_ack);
        int sh = stall_ack ? 1 : 0;
        run_entry(1'b1, 2'd3, 16'h4321, 16'h2000, stall_ack ? 64'h4 : 64'd0, op, 8'h0, 8'h0, 1'b0);
        chk(lg_acc[0] && count_set(2) == 1, "R3 accept vectored", count_set(2), 1);
        chk(lg_ack[1] && lg_ack[2 + sh] && !lg_ack[0] && count_set(1) == 2 + sh, "R7 ack window", count_set(1), 2 + sh);
        chk(lg_addr[1] == 16'h4321, "R7 ack address is PC", lg_addr[1], 16'h4321);
        chk(lg_irl[3 + sh] && lg_irb[3 + sh] == op, "R7 ir load", lg_irb[3 + sh], op);
        chk(lg_load[11 + sh] && lg_pcn[11 + sh] == exp_pc, "R9 restart target", lg_pcn[11 + sh], exp_pc);
        chk(lg_addr[7 + sh] == 16'h1FFF && lg_dout[7 + sh] == 8'h43, "R5 vectored push", lg_dout[7 + sh], 8'h43);
    endtask

    task automatic t_call;
        run_entry(1'b1, 2'd0, 16'hBEEF, 16'hF000, 64'd0, 8'hCD, 8'h34, 8'h12, 1'b0);
        chk(count_set(1) == 6 && lg_ack[7] && lg_ack[11] && !lg_ack[9], "R8 three ack cycles", count_set(1), 6);
        chk(lg_wr[13] && lg_addr[13] == 16'hEFFF && lg_dout[13] == 8'hBE, "R8 push after call", lg_dout[13], 8'hBE);
        chk(lg_load[17] && lg_pcn[17] == 16'h1234, "R8 call target", lg_pcn[17], 16'h1234);
        chk(end_k == 18, "R8 entry length", end_k, 18);
    endtask

    task automatic t_other_op;
        run_entry(1'b1, 2'd0, 16'h1111, 16'h3000, 64'd0, 8'h00, 8'h0, 8'h0, 1'b0);
        chk(end_k == 6, "R10 ends after ack", end_k, 6);
        chk(count_set(0) == 0 && count_set(3) == 0, "R10 no push no load", count_set(0), 0);
    endtask

    initial begin
        #1000000;
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_no_entry();
        t_direct_plain();
        t_direct_waits();
        t_restart(8'hEF, 16'h0028, 1'b0);
        t_restart(8'hC7, 16'h0000, 1'b1);
        t_restart(8'hFF, 16'h0038, 1'b0);
        t_call();
        t_other_op();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule